// File: doc/BRIEF.md
# March Element Sequencer with Fault Halt

This block runs one march element of a memory test at a time. A controlling processor hands it a 5-bit command. The command picks one of several read/write operation sequences, the order in which addresses are visited, and a data background. The block then visits every address once. At each address it performs the chosen sequence and checks every read against the value it expects.

When a read returns a wrong value, the block stops and holds the failing address and the differing bits. It stays stopped until the processor pulses a resume input. It then carries on with the next operation in the sequence. When the last operation at the last address completes, it emits a one-cycle done pulse and returns to idle, ready for the next element. A complete march test is a series of such commands.

The memory under test sits outside the block. It is single-ported and synchronous. Read data is valid on the cycle after the read request.

Top module: `march_elem_gen`

## Requirements
- R1: The command is `cmd_word[4:2]` = operation code, `cmd_word[1]` = direction, `cmd_word[0]` = background. The command is taken only while `cmd_ready` is high. `cmd_ready` is high only when idle. A command offered while an element is running or halted is not taken and changes nothing.
- R2: The operation code sets the per-address sequence (W = write, R = read):
  - 000: W R W R
  - 001: W
  - 011: W R
  - 100: R W
  - 101: R
  - 110: R W R
  - 111: R W R R

  Every address gets exactly that many memory accesses.
- R3: With direction 0, addresses go 0 up to DEPTH-1. With direction 1, they go DEPTH-1 down to 0. No access falls outside 0..DEPTH-1.
- R4: Data words are the background bit copied across all DATA_W bits, or the complement of that word. At each address, the expected value starts at the background if the sequence opens with a read, and at its complement if it opens with a write. Each write stores the complement of the current expected value and makes it the new expected value. Each read is compared, one cycle after it is issued, with the current expected value.
- R5: A read mismatch stops the element. The block raises `fault_valid`, holds the failing address on `fault_addr`, and holds the XOR of read and expected data on `fault_syn`. No memory access is made while stopped.
- R6: Resume takes effect only while stopped. The element then continues with the operation after the failing read, without repeating it.
- R7: `test_finish` is a one-cycle pulse, raised as the block returns to idle after the last operation at the last address. If that final operation is a failing read, the pulse comes only when resume is given.
- R8: Operation code 010 is taken in idle and makes no memory access or done pulse. It clears all internal state, so `fault_addr` and `fault_syn` read 0.
- R9: After reset the block is idle: `cmd_ready` = 1, `fault_valid` = 0, `test_finish` = 0, `mem_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_word | input | 5 | {operation code, direction, background} |
| resume | input | 1 | Continue after a halt |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| fault_valid | output | 1 | Halted on a mismatch |
| fault_addr | output | AW | Address of the last mismatch |
| fault_syn | output | DATA_W | Read data XOR expected data of the last mismatch |
| test_finish | output | 1 | One-cycle element-complete pulse |

## Verification
The element table runs a march test that chains all seven operation sequences in both directions and with both backgrounds. Each element reads the state the previous element left behind, so a wrong write value or a wrong read expectation shows up either as a spurious halt or as a wrong final memory image.

Access counts per element separate the sequences from one another. The first address touched separates ascending from descending order.

The faulty memory model flips chosen bits at one address. Flips in mid-array, at the final address, and near the far end in descending order test the halt, the syndrome, the no-repeat resume, and the deferred done pulse. A command offered while busy, and the clearing operation code, are checked through the memory contents and the held fault outputs.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } state_t;

    localparam int          CMD_W   = 5;
    localparam logic [2:0]  OP_INIT = 3'b010;

    // per-address operation list: index of the last step and write flags
    typedef struct packed {
        logic [1:0] last_step;
        logic [3:0] wmask;
    } shape_t;

endpackage

// File: rtl/march_shape.sv
module march_shape
    import march_pkg::*;
(
    input  logic [2:0] op,
    output shape_t     shape
);

    always_comb begin
        case (op)
            3'b000:  shape = '{last_step: 2'd3, wmask: 4'b0101};
            3'b001:  shape = '{last_step: 2'd0, wmask: 4'b0001};
            3'b011:  shape = '{last_step: 2'd1, wmask: 4'b0001};
            3'b100:  shape = '{last_step: 2'd1, wmask: 4'b0010};
            3'b101:  shape = '{last_step: 2'd0, wmask: 4'b0000};
            3'b110:  shape = '{last_step: 2'd2, wmask: 4'b0010};
            3'b111:  shape = '{last_step: 2'd3, wmask: 4'b0010};
            default: shape = '{last_step: 2'd0, wmask: 4'b0000};
        endcase
    end

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              exp_bit,
    output logic [DATA_W-1:0] syn,
    output logic              mismatch
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign syn[b] = rdata[b] ^ exp_bit;
    end

    assign mismatch = |syn;

endmodule

// File: rtl/march_elem_gen.sv
module march_elem_gen
    import march_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              resume,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fault_valid,
    output logic [AW-1:0]     fault_addr,
    output logic [DATA_W-1:0] fault_syn,
    output logic              test_finish
);

    localparam logic [AW-1:0] ADDR_TOP = AW'(DEPTH - 1);

    typedef struct packed {
        state_t            state;
        logic [2:0]        op;
        logic              dir;
        logic              bg;
        logic [AW-1:0]     addr;
        logic [1:0]        step;
        logic              val;
        logic              chk;
        logic              done;
        logic [AW-1:0]     fault_addr;
        logic [DATA_W-1:0] syn;
        logic              fin;
    } regs_t;

    regs_t r_q, r_d;

    shape_t            shape;
    logic [DATA_W-1:0] cmp_syn;
    logic              cmp_bad;

    march_shape u_shape (
        .op    (r_q.op),
        .shape (shape)
    );

    march_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rdata    (mem_rdata),
        .exp_bit  (r_q.val),
        .syn      (cmp_syn),
        .mismatch (cmp_bad)
    );

    logic          d0, cur, wrap, at_end;
    logic [1:0]    step_nx;
    logic [AW-1:0] addr_nx, addr_end;

    always_comb begin
        d0       = shape.wmask[0] ? ~r_q.bg : r_q.bg;
        cur      = (r_q.step == 2'd0) ? d0 : r_q.val;
        addr_end = r_q.dir ? '0 : ADDR_TOP;
        wrap     = (r_q.step == shape.last_step);
        at_end   = wrap && (r_q.addr == addr_end);
        step_nx  = wrap ? 2'd0 : r_q.step + 2'd1;
        if (!wrap)
            addr_nx = r_q.addr;
        else if (r_q.dir)
            addr_nx = r_q.addr - AW'(1);
        else
            addr_nx = r_q.addr + AW'(1);
    end

    always_comb begin
        r_d       = r_q;
        r_d.fin   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.addr;
        mem_wdata = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_word[4:2] == OP_INIT) begin
                        r_d = '0;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.op    = cmd_word[4:2];
                        r_d.dir   = cmd_word[1];
                        r_d.bg    = cmd_word[0];
                        r_d.addr  = cmd_word[1] ? ADDR_TOP : '0;
                        r_d.step  = 2'd0;
                        r_d.chk   = 1'b0;
                        r_d.done  = 1'b0;
                    end
                end
            end
            ST_RUN: begin
                if (!r_q.chk) begin
                    mem_en = 1'b1;
                    if (shape.wmask[r_q.step]) begin
                        mem_we    = 1'b1;
                        mem_wdata = {DATA_W{~cur}};
                        r_d.val   = ~cur;
                        r_d.step  = step_nx;
                        r_d.addr  = addr_nx;
                        if (at_end) begin
                            r_d.state = ST_IDLE;
                            r_d.fin   = 1'b1;
                        end
                    end else begin
                        r_d.val = cur;
                        r_d.chk = 1'b1;
                    end
                end else begin
                    r_d.chk  = 1'b0;
                    r_d.step = step_nx;
                    r_d.addr = addr_nx;
                    if (cmp_bad) begin
                        r_d.state      = ST_HALT;
                        r_d.fault_addr = r_q.addr;
                        r_d.syn        = cmp_syn;
                        r_d.done       = at_end;
                    end else if (at_end) begin
                        r_d.state = ST_IDLE;
                        r_d.fin   = 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (resume) begin
                    r_d.done = 1'b0;
                    if (r_q.done) begin
                        r_d.state = ST_IDLE;
                        r_d.fin   = 1'b1;
                    end else begin
                        r_d.state = ST_RUN;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready   = (r_q.state == ST_IDLE);
    assign fault_valid = (r_q.state == ST_HALT);
    assign fault_addr  = r_q.fault_addr;
    assign fault_syn   = r_q.syn;
    assign test_finish = r_q.fin;

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> ($stable(r_q.op) && $stable(r_q.dir) && $stable(r_q.bg))); // R1
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr <= ADDR_TOP)); // R3
    AST_CHECK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.chk |-> $past(mem_en && !mem_we)); // R4
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> !mem_en); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !resume) |=> (fault_valid && $stable(fault_addr))); // R6
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        test_finish |=> !test_finish); // R7
    AST_FIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        test_finish |-> cmd_ready); // R7

endmodule

// File: tb/sim_march_elem_gen.sv
module sim_march_elem_gen;

    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int AW     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [4:0]        cmd_word = '0;
    logic              resume = 1'b0;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              fault_valid;
    logic [AW-1:0]     fault_addr;
    logic [DATA_W-1:0] fault_syn;
    logic              test_finish;

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int mark = 0;
    int cyc = 0;
    logic [AW-1:0]     first_addr = '0;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              stk_en = 1'b0;
    logic [AW-1:0]     stk_addr = '0;
    logic [DATA_W-1:0] stk_mask = '0;

    always #2 clk = ~clk;

    march_elem_gen #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .resume(resume), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_syn(fault_syn),
        .test_finish(test_finish)
    );

    // memory under test with an optional bit-flip defect at one address
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else mem_rdata <= mem[mem_addr] ^ ((stk_en && mem_addr == stk_addr) ? stk_mask : '0);
            if (acc_cnt == mark) first_addr <= mem_addr;
            acc_cnt <= acc_cnt + 1;
        end
    end

    // {op[2:0], dir, bg, final bit, accesses[8:0], first address[3:0]}
    localparam logic [18:0] VEC [8] = '{
        {3'b001, 1'b0, 1'b0, 1'b0, 9'd16, 4'd0},
        {3'b100, 1'b0, 1'b0, 1'b1, 9'd32, 4'd0},
        {3'b110, 1'b1, 1'b1, 1'b0, 9'd48, 4'd15},
        {3'b111, 1'b0, 1'b0, 1'b1, 9'd64, 4'd0},
        {3'b101, 1'b1, 1'b1, 1'b1, 9'd16, 4'd15},
        {3'b000, 1'b1, 1'b0, 1'b1, 9'd64, 4'd15},
        {3'b011, 1'b0, 1'b1, 1'b1, 9'd32, 4'd0},
        {3'b011, 1'b1, 1'b0, 1'b0, 9'd32, 4'd15}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic dir, input logic bg);
        @(negedge clk);
        mark = acc_cnt;
        cmd_valid = 1'b1;
        cmd_word = {op, dir, bg};
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ev(output int what);
        what = 0;
        for (int k = 0; k < 2000; k++) begin
            if (test_finish) begin what = 1; break; end
            if (fault_valid) begin what = 2; break; end
            @(negedge clk);
        end
    endtask

    task automatic mem_all(input string tag, input logic [DATA_W-1:0] v);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[a] !== v) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic do_resume();
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    initial begin
        int w, a0;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 cmd_ready", cmd_ready, 1);
        chk("R9 fault_valid", fault_valid, 0);
        chk("R9 test_finish", test_finish, 0);
        chk("R9 mem_en", mem_en, 0);

        // march test built from the element table
        foreach (VEC[i]) begin
            issue(VEC[i][18:16], VEC[i][15], VEC[i][14]);
            wait_ev(w);
            chk("R7 element done", w, 1);
            chk("R2 access count", acc_cnt - mark, int'(VEC[i][12:4]));
            chk("R3 first address", first_addr, int'(VEC[i][3:0]));
            mem_all("R4 final contents", {DATA_W{VEC[i][13]}});
        end

        // mid-array fault, ascending, memory holds zeros
        stk_en = 1'b1; stk_addr = 4'd5; stk_mask = 8'h04;
        issue(3'b101, 1'b0, 1'b0);
        wait_ev(w);
        chk("R5 halt", w, 2);
        chk("R5 fault_addr", fault_addr, 5);
        chk("R5 fault_syn", fault_syn, 8'h04);
        chk("R1 not ready while halted", cmd_ready, 0);
        a0 = acc_cnt;
        repeat (10) @(negedge clk);
        chk("R5 still halted", fault_valid, 1);
        chk("R5 no access while halted", acc_cnt - a0, 0);
        do_resume();
        wait_ev(w);
        chk("R6 finishes after resume", w, 1);
        chk("R6 no repeated read", acc_cnt - mark, 16);

        // fault on the final read of the element
        stk_addr = 4'd15; stk_mask = 8'h80;
        issue(3'b101, 1'b0, 1'b0);
        wait_ev(w);
        chk("R5 halt at last address", w, 2);
        chk("R5 fault_addr last", fault_addr, 15);
        chk("R5 fault_syn last", fault_syn, 8'h80);
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (test_finish) seen = 1'b1;
        end
        chk("R7 no done while halted", seen, 0);
        do_resume();
        chk("R7 deferred done pulse", test_finish, 1);
        chk("R7 idle with done", cmd_ready, 1);
        @(negedge clk);
        chk("R7 done is one cycle", test_finish, 0);

        // clearing operation code
        a0 = acc_cnt;
        issue(3'b010, 1'b1, 1'b1);
        chk("R8 fault_addr cleared", fault_addr, 0);
        chk("R8 fault_syn cleared", fault_syn, 0);
        chk("R8 no done pulse", test_finish, 0);
        chk("R8 stays idle", cmd_ready, 1);
        chk("R8 no access", acc_cnt - a0, 0);

        // command offered while busy is not taken
        stk_en = 1'b0;
        issue(3'b001, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++) begin
            cmd_valid = 1'b1;
            cmd_word = {3'b001, 1'b0, 1'b0};
            chk("R1 not ready while running", cmd_ready, 0);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        wait_ev(w);
        chk("R1 running element completes", w, 1);
        mem_all("R1 busy command ignored", 8'hFF);

        // descending fault near the far end, ones background
        stk_en = 1'b1; stk_addr = 4'd2; stk_mask = 8'h01;
        issue(3'b101, 1'b1, 1'b1);
        wait_ev(w);
        chk("R3 descending halt", w, 2);
        chk("R3 descending fault_addr", fault_addr, 2);
        chk("R5 descending fault_syn", fault_syn, 8'h01);
        do_resume();
        wait_ev(w);
        chk("R6 descending completes", w, 1);
        chk("R6 descending access count", acc_cnt - mark, 16);

        finish_run();
    end

endmodule